// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer for SPI Flash

This host-side controller copies a run of bytes into an SPI serial flash with the device's auto-address-increment word program command. A start pulse supplies the even start address, the byte count and a choice of how program completion is found. The bytes then arrive on a valid/ready stream. The controller drives SCK, chip-select and MOSI in SPI mode 0 and reads MISO. Completion is found either by polling the status register or by hardware busy sensing. In the hardware method, MISO is sampled while chip-select is held low and no clocks are given.

The command flow is fixed. In hardware mode a busy-output enable command comes first. A write-enable frame follows. The first word frame carries the opcode, the 24-bit address and two data bytes. Every later word frame carries only the opcode and two data bytes. After each word, the controller waits until the device is ready before it sends anything else. After the last word it sends write-disable and waits once more. In hardware mode it finally sends the busy-output disable command. It then pulses done, with an error flag that stays valid until the next start.

Top module: `aai_flash_writer`

## Requirements
- R1: Out of reset, cs_n is high, sck is low, and in_ready, busy and done are low.
- R2: SPI mode 0 is used. SCK idles low and data goes out MSB first. MOSI changes only while SCK is low. Between frames, cs_n stays high for at least one SCK period, which is 2*CLK_DIV clock cycles.
- R3: In hardware mode the first frame is the single byte 70h. Write-enable (06h) is always sent as a frame of its own. The first word frame is six bytes: ADh, address bits 23..16, 15..8, 7..0, then the first and second data byte.
- R4: Every word frame after the first is three bytes: ADh and then two data bytes. The flash places the bytes at the next two addresses.
- R5: In polling mode each wait sends two-byte frames of 05h followed by a read byte. Bit 0 of the read byte is the busy flag (1 = busy). Polling repeats until that bit reads 0.
- R6: In hardware mode each wait check lowers cs_n for 2*CLK_DIV cycles with no SCK edges. MISO is sampled at the end of that window, where 1 means ready and 0 means busy. Checks repeat until the device reads ready.
- R7: After the last word, one wait is made. Then write-disable (04h) is sent and another wait is made. In hardware mode 80h is sent after that. Done then pulses with error low.
- R8: Exactly byte_count bytes are taken from the stream. For an odd count, the second byte of the final word is FFh.
- R9: An odd start address or a zero count gives done with error high on the cycle after start. In that case no SPI frame is sent and no byte is accepted.
- R10: If MAX_POLLS wait checks in a row all read busy, error is set and 04h is sent at once. In hardware mode 80h follows. Done then pulses with no further waits.
- R11: Done is high for exactly one cycle. Error holds its value until the next accepted start. A start while busy is ignored.
- R12: in_ready is high only between frames, with cs_n high. Gaps in in_valid only delay the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program run (sampled when idle) |
| start_addr | input | 24 | First flash address, must be even |
| byte_count | input | LEN_W | Number of bytes to program |
| hw_mode | input | 1 | 1 = sense busy on MISO, 0 = poll status |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Controller takes the byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Run failed (bad start or timeout) |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip-select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
Assertions check the following on every cycle. SCK stays low whenever chip-select is high. MOSI holds steady across each high SCK phase. No frame opens without the minimum chip-select gap. The stream handshake only happens with chip-select high. Done is a one-cycle pulse. A bad start completes with error on the next cycle. The bench scenarios cover what only a whole transfer can show. A behavioural flash model logs every frame and stores the programmed bytes. From its log the bench checks the command order, the frame lengths, the address and the FFh padding. It also checks the number of status polls or hardware checks per wait, and the timeout path with its trailing write-disable in both completion modes.

// File: rtl/aai_flash_writer.sv
module aai_flash_writer #(
  parameter int CLK_DIV   = 2,
  parameter int MAX_POLLS = 64,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      start_addr,
  input  logic [LEN_W-1:0] byte_count,
  input  logic             hw_mode,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int HALF_W  = $clog2(CLK_DIV) + 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);

  typedef enum logic [3:0] {
    IDLE, EN70, WREN, FETCH, GAP, XFER, HWS, POLL, EVAL, WRDI, DIS80, FIN
  } st_t;

  st_t              st, ret, okst;
  logic [47:0]      sh;
  logic [5:0]       nb;
  logic [7:0]       rx, d0;
  logic             sck_q, cs_q, hwf, hw, first, have0, err, rdy;
  logic [HALF_W-1:0] dcnt;
  logic [GAP_W-1:0] gcnt;
  logic [POLL_W-1:0] polls;
  logic [LEN_W-1:0] rem;
  logic [23:0]      addr;

  wire [7:0] wd0   = have0 ? d0 : in_data;
  wire [7:0] wd1   = have0 ? in_data : 8'hFF;
  wire       ready = hw ? rdy : !rx[0];

  assign in_ready = (st == FETCH);
  assign busy     = (st != IDLE);
  assign done     = (st == FIN);
  assign error    = err;
  assign sck      = sck_q;
  assign cs_n     = cs_q;
  assign mosi     = sh[47];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ret <= IDLE; okst <= IDLE;
      sh <= '0; nb <= '0; rx <= '0; d0 <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1; hwf <= 1'b0; hw <= 1'b0;
      first <= 1'b0; have0 <= 1'b0; err <= 1'b0; rdy <= 1'b0;
      dcnt <= '0; gcnt <= '0; polls <= '0; rem <= '0; addr <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          hw <= hw_mode; addr <= start_addr; rem <= byte_count;
          first <= 1'b1; have0 <= 1'b0;
          if (start_addr[0] || byte_count == '0) begin
            err <= 1'b1; st <= FIN;
          end else begin
            err <= 1'b0; st <= hw_mode ? EN70 : WREN;
          end
        end
        EN70: begin
          sh <= {8'h70, 40'h0}; nb <= 6'd8; ret <= WREN;
          hwf <= 1'b0; gcnt <= '0; st <= GAP;
        end
        WREN: begin
          sh <= {8'h06, 40'h0}; nb <= 6'd8; ret <= FETCH;
          hwf <= 1'b0; gcnt <= '0; st <= GAP;
        end
        FETCH: if (in_valid) begin
          if (!have0 && rem != LEN_W'(1)) begin
            d0 <= in_data; have0 <= 1'b1;
          end else begin
            sh <= first ? {8'hAD, addr, wd0, wd1} : {8'hAD, wd0, wd1, 24'h0};
            nb <= first ? 6'd48 : 6'd24;
            first <= 1'b0; have0 <= 1'b0;
            rem <= rem - ((rem == LEN_W'(1)) ? LEN_W'(1) : LEN_W'(2));
            okst <= (rem <= LEN_W'(2)) ? WRDI : FETCH;
            polls <= '0; ret <= POLL; hwf <= 1'b0; gcnt <= '0; st <= GAP;
          end
        end
        GAP: begin
          if (gcnt == GAP_W'(GAP_CYC - 1)) begin
            cs_q <= 1'b0; gcnt <= '0; dcnt <= '0;
            st <= hwf ? HWS : XFER;
          end else gcnt <= gcnt + 1'b1;
        end
        XFER: begin
          if (dcnt == HALF_W'(CLK_DIV - 1)) begin
            dcnt <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1; rx <= {rx[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              if (nb == 6'd1) begin
                cs_q <= 1'b1; st <= ret;
              end else begin
                sh <= {sh[46:0], 1'b0}; nb <= nb - 1'b1;
              end
            end
          end else dcnt <= dcnt + 1'b1;
        end
        HWS: begin
          if (gcnt == GAP_W'(GAP_CYC - 1)) begin
            rdy <= miso; cs_q <= 1'b1; st <= EVAL;
          end else gcnt <= gcnt + 1'b1;
        end
        POLL: begin
          gcnt <= '0; st <= GAP;
          if (hw) hwf <= 1'b1;
          else begin
            sh <= {8'h05, 40'h0}; nb <= 6'd16; ret <= EVAL; hwf <= 1'b0;
          end
        end
        EVAL: begin
          if (ready) st <= okst;
          else if (polls == POLL_W'(MAX_POLLS - 1)) begin
            err <= 1'b1; st <= (okst == DIS80) ? DIS80 : WRDI;
          end else begin
            polls <= polls + 1'b1; st <= POLL;
          end
        end
        WRDI: begin
          sh <= {8'h04, 40'h0}; nb <= 6'd8;
          ret <= err ? DIS80 : POLL; okst <= DIS80; polls <= '0;
          hwf <= 1'b0; gcnt <= '0; st <= GAP;
        end
        DIS80: begin
          if (hw) begin
            sh <= {8'h80, 40'h0}; nb <= 6'd8; ret <= FIN;
            hwf <= 1'b0; gcnt <= '0; st <= GAP;
          end else st <= FIN;
        end
        FIN:     st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  logic [GAP_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= GAP_W'(GAP_CYC);
    else if (!cs_q) hi_cnt <= '0;
    else if (hi_cnt != GAP_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  a_r2_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= GAP_W'(GAP_CYC)));
  a_r9_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (start_addr[0] || byte_count == '0)) |=> (done && error));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r12_ready_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> cs_n);

endmodule

// File: tb/test_aai_flash_writer.sv
module test_aai_flash_writer;
  localparam int MP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, hw_mode = 1'b0;
  logic [23:0] start_addr = '0;
  logic [15:0] byte_count = '0;
  logic [7:0] in_data;
  logic in_valid, in_ready, busy, done, error, sck, cs_n, mosi, miso;

  always #5 clk = ~clk;

  aai_flash_writer #(.CLK_DIV(2), .MAX_POLLS(MP), .LEN_W(16)) i_aai_flash_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .hw_mode(hw_mode), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .busy(busy), .done(done),
    .error(error), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0;
  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream source
  int fidx = 0, fn = 0, cyc = 0;
  logic frst = 1'b0, stall_en = 1'b0;
  assign in_valid = (fidx < fn) && (!stall_en || (cyc % 3 == 0));
  assign in_data  = 8'hA0 + fidx[7:0];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (frst) fidx <= 0;
    else if (in_valid && in_ready) fidx <= fidx + 1;
  end

  // flash model
  logic [7:0] mem [0:255];
  logic [7:0] fr_op [0:255];
  int fr_len [0:255];
  logic [7:0] cur [0:7];
  logic [7:0] shv = '0;
  int nbits = 0, nfr = 0, n05 = 0, nhw = 0, busy_cnt = 0, busy_reload = 0;
  logic hwen = 1'b0;
  logic [23:0] aaddr = '0;

  assign miso = (!cs_n && hwen && nbits == 0) ? (busy_cnt == 0) :
                (!cs_n && nbits == 15 && cur[0] == 8'h05) ? (busy_cnt != 0) : 1'b0;

  always @(negedge cs_n) nbits = 0;
  always @(posedge sck) if (!cs_n && nbits < 64) begin
    shv = {shv[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) cur[nbits/8-1] = shv;
  end
  always @(posedge cs_n) begin
    int len;
    len = nbits / 8;
    if (nfr < 256) begin
      fr_op[nfr] = (len > 0) ? cur[0] : 8'h00;
      fr_len[nfr] = len;
      nfr++;
    end
    if (len == 0) begin
      nhw++;
      if (busy_cnt > 0) busy_cnt--;
    end else case (cur[0])
      8'h70: hwen = 1'b1;
      8'h80: hwen = 1'b0;
      8'h05: begin n05++; if (busy_cnt > 0) busy_cnt--; end
      8'h04: busy_cnt = busy_reload;
      8'hAD: begin
        if (len == 6) aaddr = {cur[1], cur[2], cur[3]};
        mem[aaddr[7:0]] = cur[len-2];
        mem[aaddr[7:0]+8'd1] = cur[len-1];
        aaddr = aaddr + 24'd2;
        busy_cnt = busy_reload;
      end
      default: ;
    endcase
  end

  // shortest chip-select high stretch during a run
  int hc = 0, min_gap = 1000;
  always @(negedge clk) begin
    if (cs_n) hc++;
    else begin
      if (hc > 0 && hc < min_gap) min_gap = hc;
      hc = 0;
    end
  end

  logic run_err;
  logic [7:0] seq [0:15];
  int nseq;

  task automatic run(input logic [23:0] a, input int cnt, input logic hw,
                     input logic stl, input int reload, input logic inject);
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    nfr = 0; n05 = 0; nhw = 0; busy_cnt = 0; busy_reload = reload; hwen = 1'b0;
    frst = 1'b1; stall_en = stl;
    @(negedge clk);
    frst = 1'b0; fn = cnt;
    start_addr = a; byte_count = cnt[15:0]; hw_mode = hw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    min_gap = 1000;
    for (int k = 0; k < 60000; k++) begin
      if (done) break;
      start = (inject && k == 30);
      start_addr = inject ? 24'h000001 : a;
      @(negedge clk);
    end
    start = 1'b0;
    run_err = error;
    nseq = 0;
    for (int i = 0; i < nfr; i++)
      if (fr_len[i] > 0 && fr_op[i] != 8'h05 && nseq < 16) begin
        seq[nseq] = fr_op[i]; nseq++;
      end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 in_ready", in_ready, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_poll_mode();
    run(24'h000010, 4, 1'b0, 1'b0, 2, 1'b1);
    check("R7 error low", run_err, 0);
    check("R11 start while busy ignored", run_err, 0);
    check("R3 R4 R7 opcode count", nseq, 4);
    check("R3 wren", seq[0], 8'h06);
    check("R3 first word op", seq[1], 8'hAD);
    check("R4 later word op", seq[2], 8'hAD);
    check("R7 wrdi", seq[3], 8'h04);
    check("R3 first word len", fr_len[1], 6);
    check("R5 rdsr len", fr_len[2], 2);
    check("R4 second word len", fr_len[5], 3);
    check("R5 poll count", n05, 9);
    check("R6 no hw checks", nhw, 0);
    for (int i = 0; i < 4; i++) check("R3 R4 data", mem[8'h10+i], 8'hA0 + i);
    check("R8 bytes taken", fidx, 4);
    check("R2 cs gap", (min_gap >= 4) ? 1 : 0, 1);
  endtask

  task automatic t_hw_mode_odd();
    run(24'h000040, 3, 1'b1, 1'b0, 1, 1'b0);
    check("R7 error low", run_err, 0);
    check("R3 R7 opcode count", nseq, 6);
    check("R3 en70 first", seq[0], 8'h70);
    check("R3 wren", seq[1], 8'h06);
    check("R4 words", {seq[2], seq[3]}, 16'hADAD);
    check("R7 wrdi then 80", {seq[4], seq[5]}, 16'h0480);
    check("R6 hw check count", nhw, 6);
    check("R6 no rdsr", n05, 0);
    check("R8 data", {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'hA0A1A2);
    check("R8 pad FF", mem[8'h43], 8'hFF);
    check("R8 bytes taken", fidx, 3);
  endtask

  task automatic t_stall();
    run(24'h000080, 6, 1'b0, 1'b1, 0, 1'b0);
    check("R12 error low", run_err, 0);
    for (int i = 0; i < 6; i++) check("R12 data under stall", mem[8'h80+i], 8'hA0 + i);
    check("R5 single poll per wait", n05, 4);
  endtask

  task automatic t_bad_start(input logic [23:0] a, input int cnt);
    @(negedge clk);
    nfr = 0; frst = 1'b1;
    @(negedge clk);
    frst = 1'b0; fn = 4;
    start_addr = a; byte_count = cnt[15:0]; hw_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 done next cycle", done, 1);
    check("R9 error", error, 1);
    @(negedge clk);
    check("R11 done one cycle", done, 0);
    check("R11 error held", error, 1);
    repeat (20) @(negedge clk);
    check("R9 no frames", nfr, 0);
    check("R9 no bytes", fidx, 0);
  endtask

  task automatic t_timeout(input logic hw);
    run(24'h000000, 2, hw, 1'b0, 1000, 1'b0);
    check("R10 error", run_err, 1);
    if (hw) begin
      check("R10 opcode count hw", nseq, 5);
      check("R10 wrdi then 80", {seq[3], seq[4]}, 16'h0480);
      check("R10 hw checks", nhw, MP);
    end else begin
      check("R10 opcode count", nseq, 3);
      check("R10 wrdi", seq[2], 8'h04);
      check("R10 polls", n05, MP);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_poll_mode();
    t_hw_mode_odd();
    t_stall();
    t_bad_start(24'h000021, 4);
    t_bad_start(24'h000020, 0);
    t_timeout(1'b0);
    t_timeout(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule